// File: doc/BRIEF.md
# CAN Controller Operating Mode Sequencer

This block owns the control word and the reset-status word that move a CAN controller between its low-power sleep state and its reset, halt and running modes. Software writes a 16-bit control word that carries a mode request, a sleep request, a bus-off recovery policy and the frame-handling selects (identifier format, lost-message policy, FIFO mailbox mode). The requested mode is visible in the control readback at once. The settled mode, which gates the rest of the controller, follows only after a programmable settling delay. A forced reset is the exception and settles on the next clock.

The settled mode qualifies the controller's outputs. Receive and transmit FIFO enables and the bus transmit line reach the bus only while the controller runs and is not asleep. Otherwise the FIFO enables are held low and the transmit line is held recessive. A bus-off event can move a running controller into halt without software, provided the recovery policy asks for it. The status word shows, in bit 8, whether the settled mode is a reset mode.

Top module: `canmode_seq`

## Requirements
- R1: After reset the control readback is 0x0500: sleep bit set and mode field 1. The status readback is 0x0100, the settled mode is 1, `op_active` is 0, `can_tx` is 1 and every FIFO enable is 0.
- R2: The mode field sits in control bits 9:8 with 0 run, 1 reset, 2 halt and 3 forced reset. A write shows the new field in the readback on the write edge. For a target of 0, 1 or 2 that differs from the settled mode, `mode_now` takes the target exactly SETTLE_CYC clock edges after the write edge.
- R3: A write of mode 3 from any other settled mode makes `mode_now` equal to 3 on the first edge after the write edge.
- R4: Status bit 8 is 1 exactly when the settled mode is 1 or 3. It changes only when the settled mode changes, so during the settling delay it keeps its previous value.
- R5: A write whose mode field equals the settled mode cancels any pending change, and the settled mode stays as it was.
- R6: The configuration fields are recovery policy (bits 12:11), lost-message policy (bit 3), identifier format (bits 2:1) and FIFO mailbox mode (bit 0). A write changes them only when the settled mode at the write edge is 1 or 3. In any other mode they keep their value. The outputs `idfmt`, `lost_keep` and `fifo_mbx_mode` mirror bits 2:1, 3 and 0.
- R7: The sleep bit (bit 10) can be set only when the settled mode is not 0 and the same write requests a mode other than 0. Otherwise a write leaves the bit at 0. `in_sleep` mirrors the bit.
- R8: A `busoff_evt` pulse with a recovery policy of 1, in settled mode 0 with no change pending, writes 2 into the mode field. Halt then settles SETTLE_CYC edges later, and a software write on the same edge is dropped. With any other policy the pulse has no effect.
- R9: `op_active` is 1 only in settled mode 0 with the sleep bit clear. While it is 1, `can_tx` follows `tx_raw` and each FIFO enable follows its request. Otherwise `can_tx` is 1 and the enables are 0.
- R10: Control bits 15:13 and 7:4 always read 0. Every status bit other than bit 8 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Control word write value |
| busoff_evt | input | 1 | Bus-off entry pulse from the protocol engine |
| fifo_req | input | N_FIFO | FIFO enable requests (lane 0 receive, lane 1 transmit) |
| tx_raw | input | 1 | Transmit bit from the protocol engine |
| ctrl_q | output | 16 | Control word readback |
| stat_q | output | 16 | Status word readback (bit 8 reset reached) |
| mode_now | output | 2 | Settled operating mode |
| in_sleep | output | 1 | Sleep bit in force |
| op_active | output | 1 | Controller running and awake |
| fifo_en | output | N_FIFO | Qualified FIFO enables |
| can_tx | output | 1 | Bus transmit line, 1 is recessive |
| idfmt | output | 2 | Identifier format select |
| lost_keep | output | 1 | Lost-message policy select |
| fifo_mbx_mode | output | 1 | FIFO mailbox mode select |

## Verification
A counter that settles one edge early or late shows up as `mode_now` and status bit 8 moving in the wrong cycle, and a full sweep of source and target modes exposes it. A wrong acceptance decision for configuration or sleep shows up in the readback word on the first negative edge after the write. A gating fault appears on `can_tx` or `fifo_en` in the same cycle the settled mode or sleep bit changes. A bus-off policy fault appears as a mode field that is not 2 one edge after the pulse.

// File: rtl/canmode_pkg.sv
package canmode_pkg;

  typedef enum logic [1:0] {
    MD_RUN  = 2'd0,
    MD_RST  = 2'd1,
    MD_HALT = 2'd2,
    MD_FRST = 2'd3
  } mode_e;

  // control word field positions (software decodes these)
  localparam int unsigned B_MBX    = 0;
  localparam int unsigned B_IDF_LO = 1;
  localparam int unsigned B_LOST   = 3;
  localparam int unsigned B_MODE   = 8;
  localparam int unsigned B_SLEEP  = 10;
  localparam int unsigned B_BOR    = 11;
  localparam int unsigned B_RSTF   = 8;

  localparam logic [15:0] CFG_MASK   = 16'h180F;
  localparam logic [15:0] CTRL_RESET = 16'h0500;
  localparam logic [1:0]  BOR_HALT   = 2'd1;

  function automatic logic is_reset_mode(mode_e m);
    return (m == MD_RST) || (m == MD_FRST);
  endfunction

  // edges from write edge until the settled mode follows (0 = cancel)
  function automatic int unsigned settle_len(mode_e from_m, mode_e to_m,
                                             int unsigned dly);
    if (to_m == from_m) return 0;
    if (to_m == MD_FRST) return 1;
    return dly;
  endfunction

endpackage

// File: rtl/canmode_ctrl_reg.sv
module canmode_ctrl_reg
  import canmode_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 6,
  parameter int unsigned CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [15:0]   wr_data,
  input  logic          busoff_evt,
  input  mode_e         cur_mode,
  input  logic          pending,
  output logic [15:0]   ctrl_q,
  output logic          kick,
  output logic [CW-1:0] kick_len
);

  logic [15:0] ctrl_d;
  logic        busoff_hit;
  mode_e       wr_mode;

  assign wr_mode    = mode_e'(wr_data[B_MODE +: 2]);
  assign busoff_hit = busoff_evt && (ctrl_q[B_BOR +: 2] == BOR_HALT) &&
                      (cur_mode == MD_RUN) && !pending;

  always_comb begin
    ctrl_d   = ctrl_q;
    kick     = 1'b0;
    kick_len = '0;
    if (busoff_hit) begin
      ctrl_d[B_MODE +: 2] = MD_HALT;
      kick                = 1'b1;
      kick_len            = CW'(SETTLE_CYC);
    end else if (wr_en) begin
      if (is_reset_mode(cur_mode))
        ctrl_d = (ctrl_q & ~CFG_MASK) | (wr_data & CFG_MASK);
      ctrl_d[B_SLEEP]     = wr_data[B_SLEEP] && (cur_mode != MD_RUN) &&
                            (wr_mode != MD_RUN);
      ctrl_d[B_MODE +: 2] = wr_mode;
      kick                = 1'b1;
      kick_len            = CW'(settle_len(cur_mode, wr_mode, SETTLE_CYC));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= CTRL_RESET;
    else        ctrl_q <= ctrl_d;
  end

endmodule

// File: rtl/canmode_settle.sv
module canmode_settle
  import canmode_pkg::*;
#(
  parameter int unsigned CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kick,
  input  logic [CW-1:0] kick_len,
  input  mode_e         target,
  output mode_e         cur_mode,
  output logic          pending,
  output logic          apply_evt
);

  logic [CW-1:0] cnt;

  assign pending   = (cnt != '0);
  assign apply_evt = !kick && (cnt == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      cur_mode <= MD_RST;
    end else begin
      if (kick)         cnt <= kick_len;
      else if (pending) cnt <= cnt - CW'(1);
      if (apply_evt)    cur_mode <= target;
    end
  end

endmodule

// File: rtl/canmode_gate.sv
module canmode_gate
  import canmode_pkg::*;
#(
  parameter int unsigned N_FIFO = 2
) (
  input  mode_e             cur_mode,
  input  logic              sleep_bit,
  input  logic [N_FIFO-1:0] fifo_req,
  input  logic              tx_raw,
  output logic              op_active,
  output logic [N_FIFO-1:0] fifo_en,
  output logic              can_tx
);

  assign op_active = (cur_mode == MD_RUN) && !sleep_bit;
  assign can_tx    = op_active ? tx_raw : 1'b1;

  for (genvar g = 0; g < N_FIFO; g++) begin : g_lane
    assign fifo_en[g] = fifo_req[g] && op_active;
  end

endmodule

// File: rtl/canmode_seq.sv
module canmode_seq
  import canmode_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 6,
  parameter int unsigned N_FIFO = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [15:0]       wr_data,
  input  logic              busoff_evt,
  input  logic [N_FIFO-1:0] fifo_req,
  input  logic              tx_raw,
  output logic [15:0]       ctrl_q,
  output logic [15:0]       stat_q,
  output logic [1:0]        mode_now,
  output logic              in_sleep,
  output logic              op_active,
  output logic [N_FIFO-1:0] fifo_en,
  output logic              can_tx,
  output logic [1:0]        idfmt,
  output logic              lost_keep,
  output logic              fifo_mbx_mode
);

  localparam int unsigned CW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC + 1);

  mode_e         cur_mode;
  logic          pending;
  logic          apply_evt;
  logic          kick;
  logic [CW-1:0] kick_len;

  canmode_ctrl_reg #(.SETTLE_CYC(SETTLE_CYC), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .busoff_evt(busoff_evt), .cur_mode(cur_mode), .pending(pending),
    .ctrl_q(ctrl_q), .kick(kick), .kick_len(kick_len)
  );

  canmode_settle #(.CW(CW)) u_settle (
    .clk(clk), .rst_n(rst_n), .kick(kick), .kick_len(kick_len),
    .target(mode_e'(ctrl_q[B_MODE +: 2])), .cur_mode(cur_mode),
    .pending(pending), .apply_evt(apply_evt)
  );

  canmode_gate #(.N_FIFO(N_FIFO)) u_gate (
    .cur_mode(cur_mode), .sleep_bit(ctrl_q[B_SLEEP]), .fifo_req(fifo_req),
    .tx_raw(tx_raw), .op_active(op_active), .fifo_en(fifo_en),
    .can_tx(can_tx)
  );

  always_comb begin
    stat_q         = '0;
    stat_q[B_RSTF] = is_reset_mode(cur_mode);
  end

  assign mode_now      = cur_mode;
  assign in_sleep      = ctrl_q[B_SLEEP];
  assign idfmt         = ctrl_q[B_IDF_LO +: 2];
  assign lost_keep     = ctrl_q[B_LOST];
  assign fifo_mbx_mode = ctrl_q[B_MBX];

endmodule

// File: rtl/canmode_seq_chk.sv
module canmode_seq_chk #(
  parameter int unsigned N_FIFO = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode_now,
  input logic              stat_rst,
  input logic              sleep_bit,
  input logic [1:0]        mode_fld,
  input logic [1:0]        bor_fld,
  input logic [3:0]        cfg_lo,
  input logic              op_active,
  input logic              can_tx,
  input logic [N_FIFO-1:0] fifo_en,
  input logic              busoff_evt,
  input logic              apply_evt,
  input logic              pending
);

  assert_mode_on_apply_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_now != $past(mode_now)) |-> $past(apply_evt));

  assert_flag_on_apply_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rst != $past(stat_rst)) |-> $past(apply_evt));

  assert_cfg_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ({bor_fld, cfg_lo} != $past({bor_fld, cfg_lo})) |->
      ($past(mode_now) == 2'd1 || $past(mode_now) == 2'd3));

  assert_sleep_not_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_bit |-> (mode_now != 2'd0));

  assert_busoff_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busoff_evt && bor_fld == 2'd1 && mode_now == 2'd0 && !pending) |=>
      (mode_fld == 2'd2 && pending));

  assert_idle_recessive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !op_active |-> (can_tx && fifo_en == '0));

endmodule

bind canmode_seq canmode_seq_chk #(.N_FIFO(N_FIFO)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_now(mode_now), .stat_rst(stat_q[8]),
  .sleep_bit(ctrl_q[10]), .mode_fld(ctrl_q[9:8]), .bor_fld(ctrl_q[12:11]),
  .cfg_lo(ctrl_q[3:0]), .op_active(op_active), .can_tx(can_tx),
  .fifo_en(fifo_en), .busoff_evt(busoff_evt), .apply_evt(apply_evt),
  .pending(pending)
);

// File: tb/canmode_seq_bench.sv
`timescale 1ns/1ps
module canmode_seq_bench;

  localparam int D = 5;
  localparam int NF = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [15:0]   wr_data = '0;
  logic          busoff_evt = 1'b0;
  logic [NF-1:0] fifo_req = '0;
  logic          tx_raw = 1'b1;
  logic [15:0]   ctrl_q, stat_q;
  logic [1:0]    mode_now, idfmt;
  logic          in_sleep, op_active, can_tx, lost_keep, fifo_mbx_mode;
  logic [NF-1:0] fifo_en;

  int nchk = 0;
  int nbad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  canmode_seq #(.SETTLE_CYC(D), .N_FIFO(NF)) u_canmode_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .busoff_evt(busoff_evt), .fifo_req(fifo_req), .tx_raw(tx_raw),
    .ctrl_q(ctrl_q), .stat_q(stat_q), .mode_now(mode_now),
    .in_sleep(in_sleep), .op_active(op_active), .fifo_en(fifo_en),
    .can_tx(can_tx), .idfmt(idfmt), .lost_keep(lost_keep),
    .fifo_mbx_mode(fifo_mbx_mode)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] mw(input int m);
    return 16'(m) << 8;
  endfunction

  function automatic int exp_lat(input int f, input int t);
    if (t == f) return 0;
    if (t == 3) return 1;
    return D;
  endfunction

  function automatic int rflag(input int m);
    return (m == 1 || m == 3) ? 1 : 0;
  endfunction

  task automatic goto(input logic [15:0] d);
    wr(d);
    idle(D + 1);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nbad++;
      nchk++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    eq("R1 ctrl", ctrl_q, 16'h0500);
    eq("R1 stat", stat_q, 16'h0100);
    eq("R1 mode", mode_now, 1);
    eq("R1 op_active", op_active, 0);
    eq("R1 can_tx", can_tx, 1);
    eq("R1 fifo_en", fifo_en, 0);

    // R2 R3 R4 R5 sweep of every source/target pair
    for (int f = 0; f < 4; f++) begin
      for (int t = 0; t < 4; t++) begin
        int lat;
        goto(mw(f));
        eq("R2 source settled", mode_now, f);
        wr(mw(t));
        eq("R2 readback", ctrl_q[9:8], t);
        lat = exp_lat(f, t);
        if (lat == 0) begin
          idle(D + 1);
          eq("R5 cancel holds", mode_now, f);
        end else begin
          idle(lat - 1);
          eq(lat == 1 ? "R3 before" : "R2 before", mode_now, f);
          eq("R4 flag kept", stat_q[8], rflag(f));
          idle(1);
          eq(lat == 1 ? "R3 forced" : "R2 settled", mode_now, t);
          eq("R4 flag new", stat_q[8], rflag(t));
        end
      end
    end

    // R6 configuration acceptance
    goto(mw(1));
    wr(mw(1) | 16'h080D);
    eq("R6 idfmt in reset", idfmt, 2);
    eq("R6 lost in reset", lost_keep, 1);
    eq("R6 mbx in reset", fifo_mbx_mode, 1);
    eq("R6 bor in reset", ctrl_q[12:11], 1);
    goto(mw(0) | 16'h080D);
    eq("R6 running", mode_now, 0);
    wr(mw(0));
    eq("R6 ignored in run", ctrl_q & 16'h180F, 16'h080D);
    goto(mw(2));
    wr(mw(2) | 16'h1002);
    eq("R6 ignored in halt", ctrl_q & 16'h180F, 16'h080D);

    // R7 sleep acceptance, R9 in sleep
    tx_raw = 1'b0;
    fifo_req = 2'b11;
    wr(mw(2) | 16'h0400);
    eq("R7 sleep in halt", in_sleep, 1);
    eq("R9 asleep tx", can_tx, 1);
    eq("R9 asleep fifo", fifo_en, 0);
    wr(mw(0) | 16'h0400);
    eq("R7 sleep with run request", ctrl_q[10], 0);
    idle(D);
    eq("R7 run reached", mode_now, 0);
    wr(mw(2) | 16'h0400);
    eq("R7 sleep refused in run", ctrl_q[10], 0);
    idle(D + 1);
    goto(mw(0));

    // R9 gating while running
    eq("R9 op_active", op_active, 1);
    @(negedge clk);
    fifo_req = 2'b10;
    tx_raw = 1'b0;
    #1;
    eq("R9 fifo pass", fifo_en, 2'b10);
    eq("R9 tx pass low", can_tx, 0);
    tx_raw = 1'b1;
    #1;
    eq("R9 tx pass high", can_tx, 1);
    tx_raw = 1'b0;

    // R8 bus-off with policy 1
    @(negedge clk);
    busoff_evt = 1'b1;
    wr_en = 1'b1;
    wr_data = mw(1);
    @(negedge clk);
    busoff_evt = 1'b0;
    wr_en = 1'b0;
    eq("R8 field halt", ctrl_q[9:8], 2);
    idle(D - 1);
    eq("R8 still run", mode_now, 0);
    idle(1);
    eq("R8 halted", mode_now, 2);
    eq("R8 tx recessive", can_tx, 1);
    eq("R8 fifo off", fifo_en, 0);

    // R8 other policy: no effect
    goto(mw(1));
    goto(mw(0));
    eq("R8 policy cleared", ctrl_q[12:11], 0);
    @(negedge clk);
    busoff_evt = 1'b1;
    @(negedge clk);
    busoff_evt = 1'b0;
    idle(D + 1);
    eq("R8 no effect field", ctrl_q[9:8], 0);
    eq("R8 no effect mode", mode_now, 0);

    // R10 reserved bits
    goto(mw(1));
    wr(16'hE1F0);
    eq("R10 ctrl reserved", ctrl_q & 16'hE0F0, 0);
    eq("R10 stat others", stat_q & 16'hFEFF, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule